// File: doc/BRIEF.md
# Cipher Feed Controller

This block sits between a block-cipher core and system memory and moves data in both directions through two word-wide channels. The receive channel fetches words from memory, queues them in a small FIFO and hands them to the cipher. The transmit channel queues words produced by the cipher and writes them back to memory. Each channel is programmed through three registers: a start address, a byte length and a control word holding a byte-swap option and a FIFO flush strobe.

A channel starts the moment its length register is written, using whatever start address is already loaded. Software therefore loads the address first and the length last. When the final word of a channel has moved, the channel raises a completion flag. Interrupt enables are changed only by writing ones to a set register or to a clear register, so no read-modify-write is needed. Pending flags are cleared by writing ones to the acknowledge register, and a single registered line signals any enabled pending source.

The memory side and the cipher side are modelled as simple word handshakes. A word moves in any cycle in which both request and acknowledge, or valid and ready, are high.

Top module: `cipher_feed_ctrl`

## Requirements
- R1: After reset, every register reads zero except the FIFO status register, which reads 0x50 (both FIFOs empty), and `irq` is low.
- R2: Writing a legal length to a channel's length register (offset 0x24 receive, 0x34 transmit) while the channel is idle starts it at the address last written to its address register (0x20 receive, 0x30 transmit). The channel moves exactly length/4 words, at addresses that rise by 4 from the start address.
- R3: A length is legal only if it is nonzero and a multiple of 16. Writing an illegal length starts nothing and leaves the length register unchanged.
- R4: While a channel is busy, writes to its address and length registers are ignored. Those registers read back the next address and the number of bytes still to move.
- R5: When a channel moves its last word, it sets its completion bit in the status register at 0x00: bit 3 for receive and bit 2 for transmit.
- R6: Writing a 1 to a bit of the enable-set register (0x04) enables that source, and writing a 1 to the same bit of the enable-clear register (0x08) disables it. Zero bits leave enables unchanged, and both offsets read back the enable mask.
- R7: Writing a 1 to a bit of the acknowledge register (0x0C) clears that status bit, and zero bits have no effect. Reading 0x0C returns status AND enable.
- R8: A completion event in the same cycle as an acknowledge of the same bit wins, so the status bit stays set.
- R9: `irq` is a registered output that is high when any status bit is set and enabled, and low otherwise.
- R10: When bit 1 of a channel's control register (0x28 receive, 0x38 transmit) is set, each 32-bit word is byte-reversed on its way to the cipher (receive) or to memory (transmit).
- R11: Writing a 1 to bit 0 of a channel's control register empties that channel's FIFO in one cycle. The FIFO status register at 0x10 shows receive full at bit 7, receive empty at bit 6, transmit full at bit 5 and transmit empty at bit 4.
- R12: Status bits 1 and 0, which belong to channels this block does not contain, always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, registered one cycle later |
| rx_mem_req | output | 1 | Receive channel requests a memory word |
| rx_mem_addr | output | ADDR_W | Address of the requested word |
| rx_mem_ack | input | 1 | Memory returns the requested word this cycle |
| rx_mem_data | input | 32 | Word returned by memory |
| cin_valid | output | 1 | Word available for the cipher |
| cin_data | output | 32 | Word for the cipher |
| cin_ready | input | 1 | Cipher accepts the word |
| cout_valid | input | 1 | Cipher offers an output word |
| cout_data | input | 32 | Cipher output word |
| cout_ready | output | 1 | Transmit FIFO can accept a word |
| tx_mem_req | output | 1 | Transmit channel requests a memory write |
| tx_mem_addr | output | ADDR_W | Write address |
| tx_mem_data | output | 32 | Write data |
| tx_mem_ack | input | 1 | Memory takes the write this cycle |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the collision between a channel's final word and a software acknowledge of that same status bit in the same clock. The bench holds the transmit memory acknowledge low and releases single words one pulse at a time. When only one word remains, it raises the acknowledge for exactly one cycle in the same cycle as the write to the acknowledge register, then reads status to confirm the bit survived. Busy-time readback uses the same single-pulse technique to stop a receive transfer partway through.

// File: rtl/feed_pkg.sv
package feed_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int NSRC       = 4;
  localparam int IRQ_RX     = 3;
  localparam int IRQ_TX     = 2;
  localparam int CTL_SWAP   = 1;
  localparam int CTL_FLUSH  = 0;

  localparam logic [7:0] OFS_STAT  = 8'h00;
  localparam logic [7:0] OFS_ENSET = 8'h04;
  localparam logic [7:0] OFS_ENCLR = 8'h08;
  localparam logic [7:0] OFS_ACK   = 8'h0C;
  localparam logic [7:0] OFS_FSTAT = 8'h10;
  localparam logic [7:0] OFS_RXADR = 8'h20;
  localparam logic [7:0] OFS_RXLEN = 8'h24;
  localparam logic [7:0] OFS_RXCTL = 8'h28;
  localparam logic [7:0] OFS_TXADR = 8'h30;
  localparam logic [7:0] OFS_TXLEN = 8'h34;
  localparam logic [7:0] OFS_TXCTL = 8'h38;

  function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/feed_fifo.sv
module feed_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wptr, rptr;

  assign empty = (wptr == rptr);
  assign full  = (wptr[PW] != rptr[PW]) && (wptr[PW-1:0] == rptr[PW-1:0]);
  assign dout  = mem[rptr[PW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[PW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !pop && !flush) |=> (full && $stable(wptr)));
endmodule

// File: rtl/feed_channel.sv
module feed_channel #(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int DW    = 32,
  parameter int STEP  = 4,
  parameter int BLOCK = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_we,
  input  logic          len_we,
  input  logic [DW-1:0] wdata,
  input  logic          beat,
  output logic          busy,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] remain,
  output logic          done
);
  localparam int BLK_BITS = $clog2(BLOCK);
  localparam int STEP_LSB = $clog2(STEP);
  localparam logic [AW-1:0] ASTEP = AW'(STEP);
  localparam logic [LW-1:0] LSTEP = LW'(STEP);

  logic [LW-1:0] new_len;
  logic          legal, start;

  assign new_len = wdata[LW-1:0];
  assign legal   = (new_len != '0) && (new_len[BLK_BITS-1:0] == '0);
  assign start   = len_we && !busy && legal;
  assign done    = busy && beat && (remain == LSTEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= new_len;
    end else if (busy) begin
      if (beat) begin
        cur_addr <= cur_addr + ASTEP;
        remain   <= remain - LSTEP;
        if (remain == LSTEP) busy <= 1'b0;
      end
    end else if (addr_we) begin
      cur_addr <= {wdata[AW-1:STEP_LSB], {STEP_LSB{1'b0}}};
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && beat) |=> (cur_addr == $past(cur_addr) + ASTEP));

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !beat) |=> (busy && remain == $past(remain) && cur_addr == $past(cur_addr)));
endmodule

// File: rtl/feed_irq.sv
module feed_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         ack_we,
  input  logic [N-1:0] wmask,
  output logic [N-1:0] raw,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] ack_m, set_m, clr_m;

  assign ack_m = ack_we ? wmask : '0;
  assign set_m = set_we ? wmask : '0;
  assign clr_m = clr_we ? wmask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= '0;
      en  <= '0;
      irq <= 1'b0;
    end else begin
      raw <= (raw & ~ack_m) | evt;
      en  <= (en | set_m) & ~clr_m;
      irq <= |(raw & en);
    end
  end

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((raw & $past(evt)) == $past(evt)));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_we && ((wmask & evt) == '0)) |=> ((raw & $past(wmask)) == '0));

  // R6
  en_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((en & $past(wmask)) == '0));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((raw & en) == '0) |=> !irq);
endmodule

// File: rtl/cipher_feed_ctrl.sv
module cipher_feed_ctrl
  import feed_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int BLOCK_B    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              rx_mem_req,
  output logic [ADDR_W-1:0] rx_mem_addr,
  input  logic              rx_mem_ack,
  input  logic [31:0]       rx_mem_data,
  output logic              cin_valid,
  output logic [31:0]       cin_data,
  input  logic              cin_ready,
  input  logic              cout_valid,
  input  logic [31:0]       cout_data,
  output logic              cout_ready,
  output logic              tx_mem_req,
  output logic [ADDR_W-1:0] tx_mem_addr,
  output logic [31:0]       tx_mem_data,
  input  logic              tx_mem_ack
  ,output logic             irq
);
  localparam int LPAD = WORD_W - LEN_W;
  localparam int APAD = WORD_W - ADDR_W;

  // register write decode
  logic we_rxa, we_rxl, we_rxc, we_txa, we_txl, we_txc;
  logic we_set, we_clr, we_ack;
  assign we_rxa = reg_we && (reg_addr == OFS_RXADR);
  assign we_rxl = reg_we && (reg_addr == OFS_RXLEN);
  assign we_rxc = reg_we && (reg_addr == OFS_RXCTL);
  assign we_txa = reg_we && (reg_addr == OFS_TXADR);
  assign we_txl = reg_we && (reg_addr == OFS_TXLEN);
  assign we_txc = reg_we && (reg_addr == OFS_TXCTL);
  assign we_set = reg_we && (reg_addr == OFS_ENSET);
  assign we_clr = reg_we && (reg_addr == OFS_ENCLR);
  assign we_ack = reg_we && (reg_addr == OFS_ACK);

  // control bits
  logic rx_swap, tx_swap, rx_flush, tx_flush;
  assign rx_flush = we_rxc && reg_wdata[CTL_FLUSH];
  assign tx_flush = we_txc && reg_wdata[CTL_FLUSH];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_swap <= 1'b0;
      tx_swap <= 1'b0;
    end else begin
      if (we_rxc) rx_swap <= reg_wdata[CTL_SWAP];
      if (we_txc) tx_swap <= reg_wdata[CTL_SWAP];
    end
  end

  // receive path
  logic              rx_busy, rx_done, rx_beat, rx_full, rx_empty;
  logic [LEN_W-1:0]  rx_remain;
  logic [WORD_W-1:0] rx_dout;

  assign rx_mem_req = rx_busy && !rx_full;
  assign rx_beat    = rx_mem_req && rx_mem_ack;

  feed_channel #(.AW(ADDR_W), .LW(LEN_W), .DW(WORD_W), .STEP(WORD_BYTES), .BLOCK(BLOCK_B)) u_rx_chan (
    .clk(clk), .rst(rst), .addr_we(we_rxa), .len_we(we_rxl), .wdata(reg_wdata),
    .beat(rx_beat), .busy(rx_busy), .cur_addr(rx_mem_addr), .remain(rx_remain), .done(rx_done)
  );

  feed_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_beat), .din(rx_mem_data),
    .pop(cin_valid && cin_ready), .dout(rx_dout), .full(rx_full), .empty(rx_empty)
  );

  assign cin_valid = !rx_empty;
  assign cin_data  = rx_swap ? bswap32(rx_dout) : rx_dout;

  // transmit path
  logic              tx_busy, tx_done, tx_beat, tx_full, tx_empty;
  logic [LEN_W-1:0]  tx_remain;
  logic [WORD_W-1:0] tx_dout;

  assign cout_ready = !tx_full;
  assign tx_mem_req = tx_busy && !tx_empty;
  assign tx_beat    = tx_mem_req && tx_mem_ack;

  feed_channel #(.AW(ADDR_W), .LW(LEN_W), .DW(WORD_W), .STEP(WORD_BYTES), .BLOCK(BLOCK_B)) u_tx_chan (
    .clk(clk), .rst(rst), .addr_we(we_txa), .len_we(we_txl), .wdata(reg_wdata),
    .beat(tx_beat), .busy(tx_busy), .cur_addr(tx_mem_addr), .remain(tx_remain), .done(tx_done)
  );

  feed_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(tx_flush), .push(cout_valid && cout_ready), .din(cout_data),
    .pop(tx_beat), .dout(tx_dout), .full(tx_full), .empty(tx_empty)
  );

  assign tx_mem_data = tx_swap ? bswap32(tx_dout) : tx_dout;

  // interrupts
  logic [NSRC-1:0] evt, raw, en;
  always_comb begin
    evt         = '0;
    evt[IRQ_RX] = rx_done;
    evt[IRQ_TX] = tx_done;
  end

  feed_irq #(.N(NSRC)) u_irq (
    .clk(clk), .rst(rst), .evt(evt), .set_we(we_set), .clr_we(we_clr), .ack_we(we_ack),
    .wmask(reg_wdata[NSRC-1:0]), .raw(raw), .en(en), .irq(irq)
  );

  // registered read mux
  logic [7:0] fstat;
  assign fstat = {rx_full, rx_empty, tx_full, tx_empty, 4'b0000};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        OFS_STAT:             reg_rdata <= {{(WORD_W-NSRC){1'b0}}, raw};
        OFS_ENSET, OFS_ENCLR: reg_rdata <= {{(WORD_W-NSRC){1'b0}}, en};
        OFS_ACK:              reg_rdata <= {{(WORD_W-NSRC){1'b0}}, raw & en};
        OFS_FSTAT:            reg_rdata <= {24'h0, fstat};
        OFS_RXADR:            reg_rdata <= {{APAD{1'b0}}, rx_mem_addr};
        OFS_RXLEN:            reg_rdata <= {{LPAD{1'b0}}, rx_remain};
        OFS_RXCTL:            reg_rdata <= {30'h0, rx_swap, 1'b0};
        OFS_TXADR:            reg_rdata <= {{APAD{1'b0}}, tx_mem_addr};
        OFS_TXLEN:            reg_rdata <= {{LPAD{1'b0}}, tx_remain};
        OFS_TXCTL:            reg_rdata <= {30'h0, tx_swap, 1'b0};
        default:              reg_rdata <= '0;
      endcase
    end
  end

  // R5
  rx_done_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> raw[IRQ_RX]);

  // R12
  absent_src_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (raw[1:0] == 2'b00));
endmodule

// File: tb/cipher_feed_ctrl_bench.sv
module cipher_feed_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_mem_req, rx_mem_ack = 1'b0;
  logic [31:0] rx_mem_addr, rx_mem_data;
  logic        cin_valid, cin_ready = 1'b0;
  logic [31:0] cin_data;
  logic        cout_valid = 1'b0, cout_ready;
  logic [31:0] cout_data = '0;
  logic        tx_mem_req, tx_mem_ack = 1'b0;
  logic [31:0] tx_mem_addr, tx_mem_data;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cipher_feed_ctrl u_cipher_feed_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_mem_req(rx_mem_req), .rx_mem_addr(rx_mem_addr),
    .rx_mem_ack(rx_mem_ack), .rx_mem_data(rx_mem_data), .cin_valid(cin_valid),
    .cin_data(cin_data), .cin_ready(cin_ready), .cout_valid(cout_valid),
    .cout_data(cout_data), .cout_ready(cout_ready), .tx_mem_req(tx_mem_req),
    .tx_mem_addr(tx_mem_addr), .tx_mem_data(tx_mem_data), .tx_mem_ack(tx_mem_ack), .irq(irq)
  );

  localparam logic [31:0] MEMKEY = 32'h5A5A_0000;
  assign rx_mem_data = rx_mem_addr ^ MEMKEY;

  // logs of handshakes, taken between edges
  logic [31:0] rxa_log [64];
  logic [31:0] cin_log [64];
  logic [31:0] txa_log [64];
  logic [31:0] txd_log [64];
  int rx_n = 0, cin_n = 0, tx_n = 0;

  always @(negedge clk) begin
    if (!rst && rx_mem_req && rx_mem_ack) begin rxa_log[rx_n] = rx_mem_addr; rx_n++; end
    if (!rst && cin_valid && cin_ready)   begin cin_log[cin_n] = cin_data; cin_n++; end
    if (!rst && tx_mem_req && tx_mem_ack) begin
      txa_log[tx_n] = tx_mem_addr; txd_log[tx_n] = tx_mem_data; tx_n++;
    end
  end

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_cout(input logic [31:0] d);
    @(negedge clk);
    cout_valid = 1'b1; cout_data = d;
    @(negedge clk);
    cout_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R1", "status", v, 32'h0);
    rd(8'h04, v); chk("R1", "enable", v, 32'h0);
    rd(8'h24, v); chk("R1", "rx length", v, 32'h0);
    rd(8'h10, v); chk("R1", "fifo status", v, 32'h50);
    chk("R1", "irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_enables;
    logic [31:0] v;
    wr(8'h04, 32'hC); rd(8'h04, v); chk("R6", "set", v, 32'hC);
    wr(8'h08, 32'h4); rd(8'h08, v); chk("R6", "clear one", v, 32'h8);
    wr(8'h04, 32'h0); rd(8'h04, v); chk("R6", "zero set write", v, 32'h8);
    wr(8'h08, 32'h0); rd(8'h04, v); chk("R6", "zero clear write", v, 32'h8);
    wr(8'h08, 32'hF); rd(8'h04, v); chk("R6", "clear all", v, 32'h0);
  endtask

  task automatic t_rx_basic;
    logic [31:0] v;
    int b = rx_n;
    int c = cin_n;
    cin_ready = 1'b1; rx_mem_ack = 1'b1;
    wr(8'h20, 32'h1000);
    wr(8'h24, 32);
    idle(20);
    chk("R2", "rx word count", rx_n - b, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R2", "rx address", rxa_log[b+i], 32'h1000 + 4*i);
      chk("R2", "cipher word", cin_log[c+i], (32'h1000 + 4*i) ^ MEMKEY);
    end
    rd(8'h20, v); chk("R4", "rx end address", v, 32'h1020);
    rd(8'h24, v); chk("R4", "rx end length", v, 32'h0);
    rd(8'h00, v); chk("R5", "rx status bit3", v, 32'h8);
    chk("R12", "status low bits", v & 32'h3, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    idle(2); chk("R9", "irq masked", {31'h0, irq}, 32'h0);
    wr(8'h04, 32'h8); idle(2);
    chk("R9", "irq enabled", {31'h0, irq}, 32'h1);
    rd(8'h0C, v); chk("R7", "pending read", v, 32'h8);
    wr(8'h0C, 32'h0); rd(8'h00, v); chk("R7", "zero ack", v, 32'h8);
    wr(8'h0C, 32'h8); rd(8'h00, v); chk("R7", "ack clears", v, 32'h0);
    idle(2); chk("R9", "irq drops", {31'h0, irq}, 32'h0);
    wr(8'h08, 32'h8);
  endtask

  task automatic t_illegal;
    logic [31:0] v;
    int b = rx_n;
    wr(8'h20, 32'h7000);
    wr(8'h24, 20); idle(6);
    rd(8'h24, v); chk("R3", "len 20 length", v, 32'h0);
    wr(8'h24, 0); idle(6);
    chk("R3", "no fetch", rx_n - b, 0);
    rd(8'h00, v); chk("R3", "no completion", v, 32'h0);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    int b = rx_n;
    rx_mem_ack = 1'b0;
    wr(8'h20, 32'h2000);
    wr(8'h24, 32);
    wr(8'h24, 64);
    wr(8'h20, 32'h9000);
    rd(8'h24, v); chk("R4", "busy length kept", v, 32);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); rx_mem_ack = 1'b1;
      @(negedge clk); rx_mem_ack = 1'b0;
    end
    rd(8'h24, v); chk("R4", "remaining length", v, 24);
    rd(8'h20, v); chk("R4", "next address", v, 32'h2008);
    rx_mem_ack = 1'b1; idle(20);
    chk("R4", "words moved", rx_n - b, 8);
    chk("R4", "last address", rxa_log[b+7], 32'h201C);
    wr(8'h0C, 32'hF);
  endtask

  task automatic t_swap_rx;
    int c = cin_n;
    wr(8'h28, 32'h2);
    wr(8'h20, 32'h5000);
    wr(8'h24, 16);
    idle(12);
    chk("R10", "swapped count", cin_n - c, 4);
    for (int i = 0; i < 4; i++)
      chk("R10", "rx swapped word", cin_log[c+i], rev((32'h5000 + 4*i) ^ MEMKEY));
    wr(8'h28, 32'h0);
    wr(8'h0C, 32'hF);
  endtask

  task automatic t_tx_basic;
    logic [31:0] v;
    int b = tx_n;
    for (int i = 0; i < 4; i++) push_cout(32'hC0DE_0000 + i);
    tx_mem_ack = 1'b1;
    wr(8'h30, 32'h3000);
    wr(8'h34, 16);
    idle(10);
    chk("R2", "tx word count", tx_n - b, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R2", "tx address", txa_log[b+i], 32'h3000 + 4*i);
      chk("R2", "tx data", txd_log[b+i], 32'hC0DE_0000 + i);
    end
    rd(8'h00, v); chk("R5", "tx status bit2", v, 32'h4);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    int b;
    wr(8'h0C, 32'h4); rd(8'h00, v); chk("R7", "tx flag cleared", v, 32'h0);
    wr(8'h38, 32'h2);
    tx_mem_ack = 1'b0;
    for (int i = 0; i < 4; i++) push_cout(32'h1122_3340 + i);
    b = tx_n;
    wr(8'h30, 32'h4000);
    wr(8'h34, 16);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tx_mem_ack = 1'b1;
      @(negedge clk); tx_mem_ack = 1'b0;
    end
    @(negedge clk);
    tx_mem_ack = 1'b1; reg_we = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h4;
    @(negedge clk);
    tx_mem_ack = 1'b0; reg_we = 1'b0;
    rd(8'h00, v); chk("R8", "event beats ack", v, 32'h4);
    chk("R8", "tx words", tx_n - b, 4);
    for (int i = 0; i < 4; i++)
      chk("R10", "tx swapped word", txd_log[b+i], rev(32'h1122_3340 + i));
    wr(8'h0C, 32'h4); rd(8'h00, v); chk("R7", "late ack clears", v, 32'h0);
    wr(8'h38, 32'h0);
  endtask

  task automatic t_flush;
    logic [31:0] v;
    cin_ready = 1'b0; rx_mem_ack = 1'b1;
    wr(8'h20, 32'h6000);
    wr(8'h24, 16);
    idle(8);
    rd(8'h10, v); chk("R11", "rx partly filled", v, 32'h10);
    wr(8'h28, 32'h1);
    rd(8'h10, v); chk("R11", "rx flushed", v, 32'h50);
    chk("R11", "cipher input idle", {31'h0, cin_valid}, 32'h0);
    for (int i = 0; i < 8; i++) push_cout(32'hAB00 + i);
    rd(8'h10, v); chk("R11", "tx full", v, 32'h60);
    wr(8'h38, 32'h1);
    rd(8'h10, v); chk("R11", "tx flushed", v, 32'h50);
    wr(8'h0C, 32'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL all requirements: watchdog actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_enables;
    t_rx_basic;
    t_irq;
    t_illegal;
    t_busy;
    t_swap_rx;
    t_tx_basic;
    t_collision;
    t_flush;
    idle(4);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule